// File: doc/BRIEF.md
# Serial Memory Slave

This block is the serial slave side of a small byte-wide memory. A host selects it by pulling `cs_n` low and sends a one-byte command. Some commands are followed by a two-byte address. The block then streams bytes into or out of its internal array, moving to the next location after each byte. A single-byte status word is also reachable. It holds six configuration bits and shows whether writes are currently allowed.

The serial pins are oversampled on the system clock `clk`. Each input passes through a short synchronizer, and clock edges are found by comparing successive samples. For that reason the host clock must be several times slower than `clk`. The clock polarity is not configured. The block reacts only to rising edges that occur while it is selected, so a clock that idles low and a clock that idles high both work. `ADDR_W` sets the depth of the array as 2^ADDR_W bytes. At `ADDR_W = 15` the array is 32K x 8. The default is smaller so that elaboration stays light.

Top module: `serial_mem_slave`

## Requirements
- R1: Every byte in both directions is shifted most significant bit first: commands, address bytes, write data, read data and status.
- R2: The first full byte after `cs_n` falls is decoded as a command. The command codes are: 0x06 sets the write-enable flag, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads memory and 0x02 writes memory.
- R3: A memory read or write takes a 16-bit address, high byte first. Only the low `ADDR_W` bits pick the location and the higher received bits are discarded. At full size, bit 15 is the only discarded bit.
- R4: After the address, each further byte goes to or comes from the next location. The address wraps from 2^ADDR_W-1 to 0 and the stream continues until `cs_n` rises.
- R5: A command byte that is not in the R2 list makes the block ignore all further `si` data until `cs_n` falls again. `so_oe` stays low and neither memory, status nor the write-enable flag changes.
- R6: The same command sequence works whether the serial clock idles low (mode 0) or high (mode 3), with no configuration input.
- R7: Input bits are taken on rising `sck` edges only, starting with the first rising edge after `cs_n` goes low. If the clock is already high when `cs_n` falls, that level is not counted as an edge. Clock and data activity while `cs_n` is high has no effect.
- R8: `so_o` changes only after falling `sck` edges. `so_oe` is high only while read or status-read data is being returned, and it is low whenever the block is deselected.
- R9: A status read returns {cfg[5:0], wel, 0}, with the write-enable flag at bit 1. A status write stores bits 7..2 of its data byte as cfg, and later bytes in the same selection are ignored.
- R10: Memory and status writes take effect only while the write-enable flag is set. The flag clears when `cs_n` rises at the end of any memory-write or status-write command.
- R11: `wp_n` and `hold_n` are accepted but have no effect on any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, accepted without effect |
| hold_n | input | 1 | Pause pin, accepted without effect |
| so_o | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so_o`; low means high-impedance |

## Verification
The assertions assume that `sck`, `cs_n` and `si` each stay stable for several `clk` cycles between changes. They also assume that `si` never changes at the same moment as a rising `sck`, and that `cs_n` never moves in the same cycle as an `sck` edge. The stimulus follows these rules. It drives every pin on falling `clk` edges, holds each half-period of the serial clock for six system clocks, and keeps `cs_n` away from clock transitions by a full half-period. Under those rules the synchronizer always presents one clean edge per transition, which the lockout, output-timing and write-gating properties depend on.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

  localparam logic [7:0] OP_WEN_SET = 8'h06;
  localparam logic [7:0] OP_WEN_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;

  typedef enum logic [3:0] {
    PH_IDLE, PH_OPC, PH_AHI, PH_ALO, PH_WDAT,
    PH_RDAT, PH_WSTAT, PH_RSTAT, PH_DONE, PH_LOCK
  } phase_t;

  // status word as seen by the host
  function automatic logic [7:0] stat_view(logic [5:0] cfg, logic wel);
    return {cfg, wel, 1'b0};
  endfunction

  // msb-first shift of one new bit into a byte
  function automatic logic [7:0] shift_in(logic [7:0] cur, logic b);
    return {cur[6:0], b};
  endfunction

endpackage

// File: rtl/serial_mem_sync.sv
module serial_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic bit_rise,
  output logic bit_fall,
  output logic sel_fall,
  output logic sel_rise,
  output logic din
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_V = 3'b010; // {sck, cs_n, si}

  logic [NSIG-1:0] raw, synced;
  logic sck_q, cs_q;

  assign raw = {sck, cs_n, si};

  for (genvar g = 0; g < NSIG; g++) begin : g_pipe
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_V[g]}};
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= synced[2];
      cs_q  <= synced[1];
    end
  end

  assign bit_rise = !synced[1] &&  synced[2] && !sck_q;
  assign bit_fall = !synced[1] && !synced[2] &&  sck_q;
  assign sel_fall =  cs_q && !synced[1];
  assign sel_rise = !cs_q &&  synced[1];
  assign din      = synced[0];
endmodule

// File: rtl/serial_mem_array.sv
module serial_mem_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/serial_mem_ctrl.sv
module serial_mem_ctrl
  import serial_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              din,
  input  logic [7:0]        rd_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              so_o,
  output logic              so_oe,
  output phase_t            phase,
  output logic              wel,
  output logic              byte_done,
  output logic              wr_cmd,
  output logic [ADDR_W-1:0] addr_cur
);
  function automatic logic [ADDR_W-1:0] step(logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  phase_t            ph_q;
  logic [2:0]        bits_q;
  logic [7:0]        sh_q, tx_q, ahi_q, byte_in;
  logic              so_q, oe_q, wel_q, wrc_q;
  logic [5:0]        cfg_q;
  logic [ADDR_W-1:0] addr_q, addr_new, addr_inc;

  assign byte_in   = shift_in(sh_q, din);
  assign byte_done = bit_rise && (bits_q == 3'd7);
  assign addr_new  = ADDR_W'({ahi_q, byte_in});
  assign addr_inc  = step(addr_q);

  always_comb begin
    case (ph_q)
      PH_ALO:  mem_addr = addr_new;
      PH_RDAT: mem_addr = addr_inc;
      default: mem_addr = addr_q;
    endcase
  end

  assign mem_we    = byte_done && (ph_q == PH_WDAT) && wel_q;
  assign mem_wdata = byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; bits_q <= '0; sh_q <= '0; tx_q <= '0; ahi_q <= '0;
      so_q <= 1'b0; oe_q <= 1'b0; wel_q <= 1'b0; wrc_q <= 1'b0;
      cfg_q <= '0; addr_q <= '0;
    end else if (sel_fall) begin
      ph_q <= PH_OPC; bits_q <= '0; oe_q <= 1'b0; wrc_q <= 1'b0;
    end else if (sel_rise) begin
      ph_q <= PH_IDLE; oe_q <= 1'b0; wrc_q <= 1'b0;
      if (wrc_q) wel_q <= 1'b0;
    end else begin
      if (bit_rise) begin
        sh_q   <= byte_in;
        bits_q <= bits_q + 3'd1;
      end
      if (byte_done) begin
        case (ph_q)
          PH_OPC: begin
            case (byte_in)
              OP_WEN_SET: begin wel_q <= 1'b1; ph_q <= PH_DONE; end
              OP_WEN_CLR: begin wel_q <= 1'b0; ph_q <= PH_DONE; end
              OP_STAT_RD: begin tx_q <= stat_view(cfg_q, wel_q); ph_q <= PH_RSTAT; end
              OP_STAT_WR: begin wrc_q <= 1'b1; ph_q <= PH_WSTAT; end
              OP_MEM_RD:  ph_q <= PH_AHI;
              OP_MEM_WR:  begin wrc_q <= 1'b1; ph_q <= PH_AHI; end
              default:    ph_q <= PH_LOCK;
            endcase
          end
          PH_AHI: begin ahi_q <= byte_in; ph_q <= PH_ALO; end
          PH_ALO: begin
            addr_q <= addr_new;
            if (wrc_q) ph_q <= PH_WDAT;
            else begin tx_q <= rd_byte; ph_q <= PH_RDAT; end
          end
          PH_WDAT: addr_q <= addr_inc;
          PH_RDAT: begin tx_q <= rd_byte; addr_q <= addr_inc; end
          PH_WSTAT: begin
            if (wel_q) cfg_q <= byte_in[7:2];
            ph_q <= PH_DONE;
          end
          PH_RSTAT: tx_q <= stat_view(cfg_q, wel_q);
          default: ;
        endcase
      end
      if (bit_fall && (ph_q == PH_RDAT || ph_q == PH_RSTAT)) begin
        so_q <= tx_q[7];
        tx_q <= {tx_q[6:0], 1'b0};
        oe_q <= 1'b1;
      end
    end
  end

  assign so_o     = so_q;
  assign so_oe    = oe_q;
  assign phase    = ph_q;
  assign wel      = wel_q;
  assign wr_cmd   = wrc_q;
  assign addr_cur = addr_q;
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import serial_mem_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  input  logic hold_n,
  output logic so_o,
  output logic so_oe
);
  // named internal events, used by the bound checker
  logic              ev_rise, ev_fall, ev_cs_fall, ev_cs_rise, ev_byte;
  logic              din_s, mem_we, wel, wr_cmd;
  logic [7:0]        rd_byte, wr_byte;
  logic [ADDR_W-1:0] mem_addr, addr_cur;
  phase_t            ph;
  logic              unused_pins;

  assign unused_pins = wp_n & hold_n;

  serial_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .bit_rise(ev_rise), .bit_fall(ev_fall),
    .sel_fall(ev_cs_fall), .sel_rise(ev_cs_rise), .din(din_s)
  );

  serial_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_rise(ev_rise), .bit_fall(ev_fall),
    .sel_fall(ev_cs_fall), .sel_rise(ev_cs_rise), .din(din_s),
    .rd_byte(rd_byte), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(wr_byte),
    .so_o(so_o), .so_oe(so_oe), .phase(ph), .wel(wel), .byte_done(ev_byte),
    .wr_cmd(wr_cmd), .addr_cur(addr_cur)
  );

  serial_mem_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(wr_byte), .rdata(rd_byte)
  );
endmodule

// File: rtl/serial_mem_slave_chk.sv
module serial_mem_slave_chk
  import serial_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_fall,
  input logic              ev_cs_fall,
  input logic              ev_cs_rise,
  input logic              ev_byte,
  input logic              mem_we,
  input logic              wel,
  input logic              wr_cmd,
  input phase_t            ph,
  input logic [ADDR_W-1:0] addr_cur,
  input logic              so_o,
  input logic              so_oe
);
  p_deselect_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cs_rise |=> !so_oe);

  p_so_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_fall |=> $stable(so_o));

  p_lock_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LOCK) |-> !so_oe);

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LOCK && !ev_cs_fall && !ev_cs_rise) |=> (ph == PH_LOCK));

  p_lock_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LOCK) |-> !mem_we);

  p_wel_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cs_rise && wr_cmd) |=> !wel);

  p_write_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);

  p_addr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && (ph == PH_RDAT || ph == PH_WDAT) && addr_cur == '1)
      |=> (addr_cur == '0));
endmodule

bind serial_mem_slave serial_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_fall(ev_fall), .ev_cs_fall(ev_cs_fall),
  .ev_cs_rise(ev_cs_rise), .ev_byte(ev_byte), .mem_we(mem_we), .wel(wel),
  .wr_cmd(wr_cmd), .ph(ph), .addr_cur(addr_cur), .so_o(so_o), .so_oe(so_oe)
);

// File: tb/tb_serial_mem_slave.sv
module tb_serial_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;
  localparam int AW         = 10;
  localparam int DEPTH      = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic wp_n = 1'b1, hold_n = 1'b1;
  logic so_o, so_oe;

  int total = 0, bad = 0;

  // behavioural reference state
  logic [7:0] mem_m [DEPTH];
  logic       wel_m = 1'b0;
  logic [5:0] cfg_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_mem_slave dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .wp_n(wp_n), .hold_n(hold_n), .so_o(so_o), .so_oe(so_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // R8: once deselected for a while, the output must be released
  int idle_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n || !cs_n) idle_cnt <= 0;
    else begin
      idle_cnt <= idle_cnt + 1;
      if (idle_cnt == 8) chk(so_oe == 1'b0, "R8 idle release", so_oe, 0);
    end
  end

  task automatic sel_begin(input bit m3);
    sck = m3;
    repeat (H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic sel_end(input bit m3);
    if (!m3) begin
      sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    cs_n = 1'b1;
    sck  = m3;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r,
                      output bit any_oe, output bit all_oe);
    any_oe = 0; all_oe = 1;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si  = b[i];
      repeat (H) @(negedge clk);
      r[i]   = so_o;
      any_oe = any_oe | so_oe;
      all_oe = all_oe & so_oe;
      sck = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic simple(input bit m3, input logic [7:0] op);
    logic [7:0] r; bit a, l;
    sel_begin(m3);
    xfer(op, r, a, l);
    sel_end(m3);
    chk(!a, "R8 no drive on single-byte command", a, 0);
    if (op == 8'h06) wel_m = 1'b1;
    if (op == 8'h04) wel_m = 1'b0;
  endtask

  task automatic hdr(input bit m3, input logic [7:0] op, input logic [15:0] a, output bit any);
    logic [7:0] r; bit x, l;
    sel_begin(m3);
    xfer(op, r, x, l);      any = x;
    xfer(a[15:8], r, x, l); any |= x;
    xfer(a[7:0], r, x, l);  any |= x;
  endtask

  task automatic mem_write(input bit m3, input logic [15:0] a, input logic [31:0] w,
                           input int n, input string req);
    logic [7:0] r; bit any, x, l;
    hdr(m3, 8'h02, a, any);
    for (int k = 0; k < n; k++) begin
      xfer(w[31-8*k -: 8], r, x, l);
      any |= x;
    end
    sel_end(m3);
    chk(!any, {req, " write keeps so released"}, any, 0);
    if (wel_m)
      for (int k = 0; k < n; k++) mem_m[(int'(a) + k) % DEPTH] = w[31-8*k -: 8];
    wel_m = 1'b0;
  endtask

  task automatic mem_read(input bit m3, input logic [15:0] a, input int n, input string req);
    logic [7:0] r, e; bit any, x, l;
    hdr(m3, 8'h03, a, any);
    chk(!any, {req, " header quiet"}, any, 0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r, x, l);
      e = mem_m[(int'(a) + k) % DEPTH];
      chk(r == e && l, {req, " read data"}, {l, r}, {1'b1, e});
    end
    sel_end(m3);
    chk(so_oe == 1'b0, "R8 released after read", so_oe, 0);
  endtask

  task automatic stat_read(input bit m3, input string req);
    logic [7:0] r, e; bit x, l;
    sel_begin(m3);
    xfer(8'h05, r, x, l);
    chk(!x, {req, " opcode quiet"}, x, 0);
    xfer(8'h00, r, x, l);
    sel_end(m3);
    e = {cfg_m, wel_m, 1'b0};
    chk(r == e && l, {req, " status"}, {l, r}, {1'b1, e});
  endtask

  task automatic stat_write(input bit m3, input logic [7:0] d);
    logic [7:0] r; bit x, l;
    sel_begin(m3);
    xfer(8'h01, r, x, l);
    xfer(d, r, x, l);
    xfer(8'hFF, r, x, l);   // extra byte, ignored (R9)
    sel_end(m3);
    if (wel_m) cfg_m = d[7:2];
    wel_m = 1'b0;
  endtask

  task automatic bad_cmd(input bit m3, input logic [7:0] op);
    logic [7:0] r; bit any, x, l;
    logic [7:0] tail [5] = '{8'h02, 8'h00, 8'h20, 8'h00, 8'h06};
    sel_begin(m3);
    xfer(op, r, any, l);
    foreach (tail[k]) begin
      xfer(tail[k], r, x, l);
      any |= x;
    end
    sel_end(m3);
    chk(!any, "R5 so stays released after unknown command", any, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(so_oe == 1'b0, "R8 reset", so_oe, 0);
    stat_read(0, "R9 reset");

    // R2 R6 R10: latch set and cleared, modes mixed
    simple(0, 8'h06);
    stat_read(1, "R10 R2 latch set mode3");
    simple(1, 8'h04);
    stat_read(0, "R10 latch cleared");

    // R1: asymmetric patterns, written mode 0, read back both modes
    simple(0, 8'h06);
    mem_write(0, 16'h0010, 32'h813C5AC3, 4, "R1");
    stat_read(0, "R10 latch dropped after write");
    mem_read(1, 16'h0010, 4, "R1 R6 R7 mode3");
    mem_read(0, 16'h0010, 4, "R1 R6 mode0");

    // R10: write without latch has no effect
    mem_write(0, 16'h0011, 32'hFF000000, 1, "R10");
    mem_read(0, 16'h0010, 2, "R10 ungated write");

    // R3: upper address bits discarded
    simple(0, 8'h06);
    mem_write(1, 16'hFC05, 32'hA5000000, 1, "R3");
    mem_read(0, 16'h0005, 1, "R3 low alias");
    mem_read(1, 16'h8405, 1, "R3 high alias");

    // R4: wrap at the top of the array
    simple(0, 8'h06);
    mem_write(0, 16'(DEPTH-2), 32'h11223344, 4, "R4");
    mem_read(1, 16'(DEPTH-2), 4, "R4 wrap read");

    // R5: unknown command locks out the rest of the selection
    simple(0, 8'h06);
    mem_write(0, 16'h0020, 32'h77000000, 1, "R5 setup");
    simple(1, 8'h06);
    bad_cmd(0, 8'hA5);
    stat_read(0, "R5 latch kept");
    bad_cmd(1, 8'h00);
    mem_read(0, 16'h0020, 1, "R5 memory untouched");

    // R9 R10: status write gated by latch
    stat_write(0, 8'hFC);
    stat_read(1, "R9 status written");
    stat_write(1, 8'h00);
    stat_read(0, "R10 status write gated");

    // R11: pins have no effect
    wp_n = 1'b0; hold_n = 1'b0;
    simple(0, 8'h06);
    mem_write(0, 16'h0100, 32'hDEADBEEF, 4, "R11");
    mem_read(1, 16'h0100, 4, "R11");
    wp_n = 1'b1; hold_n = 1'b1;

    // R7: activity while deselected is ignored
    for (int k = 0; k < 20; k++) begin
      sck = ~sck;
      si  = k[1];
      repeat (H) @(negedge clk);
    end
    sck = 1'b0;
    repeat (H) @(negedge clk);
    stat_read(0, "R7 idle clocks ignored");
    mem_read(1, 16'h0010, 1, "R7 memory intact");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule